// File: doc/BRIEF.md
# Power Ramp DAC Sequencer

This block produces the 10-bit input code for one control DAC. The code sets the DAC output as a fraction of full scale. Besides plain static codes, the block can play out a stored ramp profile so that an RF transmitter's power rises and falls along a chosen curve rather than jumping.

A host register interface writes profile entries into a small private RAM. The same interface sets how many entries a ramp uses and the step rate, and it issues ramp commands. A rise command walks the profile from entry 0 up to the last entry. A fall command walks it from the last entry back down to entry 0. In both cases the final entry stays on the output once the ramp ends. When no ramp is running, the host may instead write a DAC code directly.

While a ramp is in progress, the block ignores every host write and every command, so the shape and timing of the ramp cannot be disturbed.

Top module: `pramp_seq`

## Requirements
- R1: After reset, `dac_code` is 0, `busy` and `done` are low, the last-entry index is 31, the rate reload is 0 and every profile entry holds 0.
- R2: While idle, a `dac_we` cycle sets `dac_code` to `dac_wdata` from the next clock edge on.
- R3: While idle, a `ram_we` cycle stores `ram_wdata` at profile entry `ram_addr` (entries 0 to 31). Later ramps play out that value.
- R4: While idle, an `up_cmd` cycle puts entry 0 on `dac_code` and raises `busy` at the next edge. The entry index then advances by one per step until it reaches the last-entry index.
- R5: Successive ramp steps are `reload + 1` clock cycles apart, where `reload` is the value of the 16-bit rate register (written with `rate_we` while idle). `dac_code` does not change between steps.
- R6: In the cycle where the final entry appears on `dac_code`, `busy` falls and `done` is high for exactly that one cycle. The final entry then stays on the output.
- R7: While idle, a `down_cmd` cycle puts the entry at the last-entry index on `dac_code`, then steps down one entry at a time to entry 0, which it then holds.
- R8: While `busy` is high, the following are all ignored: `up_cmd`, `down_cmd`, `dac_we`, `ram_we`, `last_we` and `rate_we`.
- R9: When `up_cmd` and `down_cmd` arrive in the same idle cycle, the rising ramp is taken.
- R10: When the last-entry index is 0, a start command puts entry 0 on `dac_code` and pulses `done` at the next edge. `busy` never rises.
- R11: While idle, with no command and no direct write, `dac_code` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ram_we | input | 1 | Profile entry write strobe |
| ram_addr | input | 5 | Profile entry index to write |
| ram_wdata | input | 10 | Profile entry value |
| last_we | input | 1 | Last-entry index write strobe |
| last_wdata | input | 5 | New last-entry index |
| rate_we | input | 1 | Rate reload write strobe |
| rate_wdata | input | 16 | New rate reload value |
| up_cmd | input | 1 | Start rising ramp |
| down_cmd | input | 1 | Start falling ramp |
| dac_we | input | 1 | Direct DAC code write strobe |
| dac_wdata | input | 10 | Direct DAC code |
| dac_code | output | 10 | Code presented to the DAC |
| busy | output | 1 | Ramp in progress |
| done | output | 1 | One-cycle pulse when the final entry is reached |

## Verification
The bench targets the following corner cases:
- **Step spacing at reload 0 and at reload 3.** A counter that is off by one would present each entry one cycle early or late.
- **The zero-length ramp.** A faulty design would either hang with `busy` stuck high or never pulse `done`.
- **Falling ramps.** A design that lost the direction would run past entry 0 or stop at the wrong end.
- **A burst of every command and write in the first cycle of a ramp.** Any leak would corrupt the ongoing sequence or surface in a later ramp as a changed entry, length or rate.
- **Simultaneous rise and fall commands.** The wrong priority would make the ramp start from the last entry instead of entry 0.

// File: rtl/pramp_pkg.sv
package pramp_pkg;
    localparam int CODE_W_DFLT = 10;
    localparam int DEPTH_DFLT  = 32;
    localparam int RATE_W_DFLT = 16;

    typedef enum logic {
        DIR_RISE = 1'b0,
        DIR_FALL = 1'b1
    } ramp_dir_e;
endpackage

// File: rtl/pramp_ram.sv
module pramp_ram #(
    parameter int CODE_W = pramp_pkg::CODE_W_DFLT,
    parameter int DEPTH  = pramp_pkg::DEPTH_DFLT,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              busy_i,
    input  logic [IDX_W-1:0]  waddr_i,
    input  logic [CODE_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  raddr_i,
    output logic [CODE_W-1:0] rdata_o
);
    logic [DEPTH-1:0][CODE_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we_i && !busy_i) begin
            mem_d[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rdata_o = mem_q[raddr_i];

    // R8: profile contents frozen while a ramp runs
    assert_ram_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(mem_q));
endmodule

// File: rtl/pramp_rate.sv
module pramp_rate #(
    parameter int RATE_W = pramp_pkg::RATE_W_DFLT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_we_i,
    input  logic [RATE_W-1:0] rate_wdata_i,
    input  logic              start_i,
    input  logic              busy_i,
    output logic              tick_o
);
    typedef struct packed {
        logic [RATE_W-1:0] reload;
        logic [RATE_W-1:0] cnt;
    } rate_st_t;

    rate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rate_we_i && !busy_i) begin
            st_d.reload = rate_wdata_i;
        end
        if (start_i) begin
            st_d.cnt = st_d.reload;
        end else if (busy_i) begin
            if (st_q.cnt == '0) st_d.cnt = st_q.reload;
            else                st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = busy_i && (st_q.cnt == '0);

    // R5: with a nonzero reload, steps are never on adjacent cycles
    assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && st_q.reload != '0) |=> !tick_o);

    // R8: reload value untouched during a ramp
    assert_reload_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(st_q.reload));
endmodule

// File: rtl/pramp_ctrl.sv
module pramp_ctrl
    import pramp_pkg::*;
#(
    parameter int CODE_W = pramp_pkg::CODE_W_DFLT,
    parameter int DEPTH  = pramp_pkg::DEPTH_DFLT,
    localparam int IDX_W = $clog2(DEPTH),
    localparam logic [IDX_W-1:0] LAST_RST = IDX_W'(DEPTH - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_i,
    input  logic              down_i,
    input  logic              dac_we_i,
    input  logic [CODE_W-1:0] dac_wdata_i,
    input  logic              last_we_i,
    input  logic [IDX_W-1:0]  last_wdata_i,
    input  logic              tick_i,
    input  logic [CODE_W-1:0] rd_data_i,
    output logic [IDX_W-1:0]  rd_addr_o,
    output logic              start_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [CODE_W-1:0] dac_o
);
    typedef struct packed {
        logic              busy;
        logic              done;
        ramp_dir_e         dir;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last;
        logic [CODE_W-1:0] dac;
    } seq_st_t;

    seq_st_t          st_d, st_q;
    logic             start;
    logic [IDX_W-1:0] end_idx;
    logic [IDX_W-1:0] start_end;
    logic [IDX_W-1:0] rd_addr;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        start     = !st_q.busy && (up_i || down_i);
        end_idx   = (st_q.dir == DIR_RISE) ? st_q.last : '0;
        start_end = up_i ? st_q.last : '0;

        if (start) begin
            rd_addr = up_i ? '0 : st_q.last;
        end else if (st_q.dir == DIR_RISE) begin
            rd_addr = st_q.idx + 1'b1;
        end else begin
            rd_addr = st_q.idx - 1'b1;
        end

        if (!st_q.busy) begin
            if (last_we_i) begin
                st_d.last = last_wdata_i;
            end
            if (start) begin
                st_d.dir = up_i ? DIR_RISE : DIR_FALL;
                st_d.idx = rd_addr;
                st_d.dac = rd_data_i;
                if (rd_addr == start_end) st_d.done = 1'b1;
                else                      st_d.busy = 1'b1;
            end else if (dac_we_i) begin
                st_d.dac = dac_wdata_i;
            end
        end else if (tick_i) begin
            st_d.idx = rd_addr;
            st_d.dac = rd_data_i;
            if (rd_addr == end_idx) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.last <= LAST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr_o = rd_addr;
    assign start_o   = start;
    assign busy_o    = st_q.busy;
    assign done_o    = st_q.done;
    assign dac_o     = st_q.dac;

    // R6: done only marks the end, never a running ramp
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !st_q.busy);

    // R5: code holds between step ticks
    assert_hold_between_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !tick_i) |=> $stable(st_q.dac));

    // R11: idle code holds without a write or command
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !up_i && !down_i && !dac_we_i) |=> $stable(st_q.dac));

    // R4: the index never passes the last entry
    assert_idx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.idx <= st_q.last));

    // R8: ramp length frozen while busy
    assert_last_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> $stable(st_q.last));
endmodule

// File: rtl/pramp_seq.sv
module pramp_seq #(
    parameter int CODE_W = pramp_pkg::CODE_W_DFLT,
    parameter int DEPTH  = pramp_pkg::DEPTH_DFLT,
    parameter int RATE_W = pramp_pkg::RATE_W_DFLT,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ram_we,
    input  logic [IDX_W-1:0]  ram_addr,
    input  logic [CODE_W-1:0] ram_wdata,
    input  logic              last_we,
    input  logic [IDX_W-1:0]  last_wdata,
    input  logic              rate_we,
    input  logic [RATE_W-1:0] rate_wdata,
    input  logic              up_cmd,
    input  logic              down_cmd,
    input  logic              dac_we,
    input  logic [CODE_W-1:0] dac_wdata,
    output logic [CODE_W-1:0] dac_code,
    output logic              busy,
    output logic              done
);
    logic [IDX_W-1:0]  rd_addr;
    logic [CODE_W-1:0] rd_data;
    logic              start;
    logic              tick;
    logic              busy_int;

    pramp_ram #(.CODE_W(CODE_W), .DEPTH(DEPTH)) i_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (ram_we),
        .busy_i  (busy_int),
        .waddr_i (ram_addr),
        .wdata_i (ram_wdata),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );

    pramp_rate #(.RATE_W(RATE_W)) i_rate (
        .clk          (clk),
        .rst_n        (rst_n),
        .rate_we_i    (rate_we),
        .rate_wdata_i (rate_wdata),
        .start_i      (start),
        .busy_i       (busy_int),
        .tick_o       (tick)
    );

    pramp_ctrl #(.CODE_W(CODE_W), .DEPTH(DEPTH)) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .up_i         (up_cmd),
        .down_i       (down_cmd),
        .dac_we_i     (dac_we),
        .dac_wdata_i  (dac_wdata),
        .last_we_i    (last_we),
        .last_wdata_i (last_wdata),
        .tick_i       (tick),
        .rd_data_i    (rd_data),
        .rd_addr_o    (rd_addr),
        .start_o      (start),
        .busy_o       (busy_int),
        .done_o       (done),
        .dac_o        (dac_code)
    );

    assign busy = busy_int;
endmodule

// File: tb/test_pramp_seq.sv
module test_pramp_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ram_we = 0, last_we = 0, rate_we = 0, up_cmd = 0, down_cmd = 0, dac_we = 0;
    logic [4:0]  ram_addr = 0, last_wdata = 0;
    logic [9:0]  ram_wdata = 0, dac_wdata = 0;
    logic [15:0] rate_wdata = 0;
    logic [9:0]  dac_code;
    logic        busy, done;

    int checks = 0;
    int errors = 0;
    int prof[32];
    int last_m = 31;
    int rate_m = 0;

    always #2.5 clk = ~clk;

    pramp_seq i_pramp_seq (
        .clk(clk), .rst_n(rst_n), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .last_we(last_we), .last_wdata(last_wdata), .rate_we(rate_we), .rate_wdata(rate_wdata),
        .up_cmd(up_cmd), .down_cmd(down_cmd), .dac_we(dac_we), .dac_wdata(dac_wdata),
        .dac_code(dac_code), .busy(busy), .done(done)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        ram_we = 0; last_we = 0; rate_we = 0; up_cmd = 0; down_cmd = 0; dac_we = 0;
    endtask

    task automatic write_ram(int a, int d);
        @(negedge clk); ram_we = 1; ram_addr = 5'(a); ram_wdata = 10'(d);
        @(negedge clk); ram_we = 0;
        prof[a] = d;
    endtask

    task automatic write_last(int v);
        @(negedge clk); last_we = 1; last_wdata = 5'(v);
        @(negedge clk); last_we = 0;
        last_m = v;
    endtask

    task automatic write_rate(int v);
        @(negedge clk); rate_we = 1; rate_wdata = 16'(v);
        @(negedge clk); rate_we = 0;
        rate_m = v;
    endtask

    // Starts a ramp and follows it step by step against the model.
    task automatic run_ramp(bit dn, bit inj, bit both);
        int s = dn ? last_m : 0;
        int e = dn ? 0 : last_m;
        int idx;
        @(negedge clk); up_cmd = !dn || both; down_cmd = dn || both;
        @(negedge clk); clear_inputs();
        check(dn ? "R7 first entry" : "R3/R4/R9 first entry", dac_code, prof[s]);
        if (s == e) begin
            check("R10 done at once", done, 1);
            check("R10 busy stays low", busy, 0);
            @(negedge clk);
            check("R10 done one cycle", done, 0);
            return;
        end
        check("R4 busy high", busy, 1);
        check("R4 no done yet", done, 0);
        if (inj) begin
            up_cmd = 1; down_cmd = 1; dac_we = 1; dac_wdata = 10'h3ff;
            ram_we = 1; ram_addr = 5'd3; ram_wdata = 10'd0;
            last_we = 1; last_wdata = 5'd1; rate_we = 1; rate_wdata = 16'd0;
        end
        idx = s;
        while (idx != e) begin
            for (int c = 0; c < rate_m; c++) begin
                @(negedge clk); clear_inputs();
            end
            if (rate_m > 0) check(inj ? "R8 step hold" : "R5 hold before step", dac_code, prof[idx]);
            @(negedge clk); clear_inputs();
            idx = dn ? idx - 1 : idx + 1;
            check(dn ? "R7 step value" : (inj ? "R8 step value" : "R4/R5 step value"), dac_code, prof[idx]);
            if (idx == e) begin
                check("R6 busy falls", busy, 0);
                check("R6 done pulse", done, 1);
            end else begin
                check("R4 busy mid", busy, 1);
                check("R6 no early done", done, 0);
            end
        end
        @(negedge clk);
        check("R6 done one cycle", done, 0);
        check(dn ? "R7 holds entry 0" : "R6 holds final", dac_code, prof[e]);
    endtask

    task automatic test_reset();
        check("R1 dac zero", dac_code, 0);
        check("R1 busy low", busy, 0);
        check("R1 done low", done, 0);
        run_ramp(0, 0, 0);   // default length 31, reload 0, zero profile
    endtask

    task automatic test_direct();
        @(negedge clk); dac_we = 1; dac_wdata = 10'h155;
        @(negedge clk); dac_we = 0;
        check("R2 direct write", dac_code, 10'h155);
        repeat (3) @(negedge clk);
        check("R11 idle hold", dac_code, 10'h155);
    endtask

    task automatic test_load();
        for (int k = 0; k < 32; k++) write_ram(k, (k * 29 + 5) % 1024);
    endtask

    task automatic test_rise();
        write_last(5); write_rate(0);
        run_ramp(0, 0, 0);
        write_rate(3);
        run_ramp(0, 0, 0);
    endtask

    task automatic test_fall();
        write_last(6); write_rate(1);
        run_ramp(1, 0, 0);
    endtask

    task automatic test_zero_len();
        write_last(0); write_rate(2);
        run_ramp(0, 0, 0);
        run_ramp(1, 0, 0);
    endtask

    task automatic test_priority();
        write_last(3); write_rate(0);
        run_ramp(0, 0, 1);
    endtask

    task automatic test_ignore();
        write_last(5); write_rate(2);
        run_ramp(1, 1, 0);
        run_ramp(0, 0, 0);   // entry 3, length and rate must be unchanged
        @(negedge clk); dac_we = 1; dac_wdata = 10'h0a5;
        @(negedge clk); dac_we = 0;
        check("R2 direct after ramp", dac_code, 10'h0a5);
    endtask

    initial begin
        for (int k = 0; k < 32; k++) prof[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_direct();
        test_load();
        test_rise();
        test_fall();
        test_zero_len();
        test_priority();
        test_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule